// File: doc/BRIEF.md
# Capture Event Flag Register

This block holds the status flags of one timer channel running in input-capture mode. Five flags sit in an 8-bit register. Four of them latch capture events, one for each capture input A through D. The fifth latches a counter overflow. The edge detectors and the counter stay outside the block. They deliver single-cycle event pulses, and each pulse sets its flag on the next clock edge.

Software reads and clears the flags over a small synchronous register bus with a select, read and write strobes and 8-bit write data. The read data is always driven from the current flag state. Clearing is guarded by a handshake kept per bit. A read arms each bit with the value it returned. The next selected write clears exactly those bits that were armed at 1 and are written with 0, and it then disarms every bit. An event that arrives after the read therefore survives a clearing write that it was not read for.

A parameter picks the channel-0 variant. In that variant bit 5 is unassigned and reads 1, and a select input picks what sets flag A: an edge of an internal slow divided clock, or an edge of the A capture pin. In the other variant bit 5 is the underflow flag, which never sets in capture mode, so it reads 0, and flag A always follows the pin.

Top module: `cap_status_reg`

## Requirements
- R1: After reset every flag is 0; with the channel-0 variant the register reads 8'hE0.
- R2: A pulse on cap_evt[k] (k = 1, 2, 3) sets bit k (bit 1 = B, bit 2 = C, bit 3 = D), and the bit reads 1 in the cycle after the pulse.
- R3: A pulse on ovf_evt sets bit 4, and the bit reads 1 in the cycle after the pulse.
- R4: A flag becomes 0 only through a selected write that carries 0 in that bit position, after an earlier selected read that returned 1 for that bit.
- R5: If the last read returned 0 for a bit, a following write of 0 leaves that bit unchanged, even when the flag was set between the read and the write.
- R6: Writing 1 into a flag bit never changes it, even when the bit is armed.
- R7: If a set event and a clearing write fall in the same cycle, the flag ends at 1.
- R8: Every selected write disarms all bits, so a second write of 0 after a write of 1 does not clear the flag without a new read.
- R9: Bits 7 and 6 always read 1; in the channel-0 variant bit 5 always reads 1 (otherwise 0); writes do not change these bits.
- R10: In the channel-0 variant, with a_src_pin = 0 flag A (bit 0) is set by lsclk_evt and cap_evt[0] is ignored; with a_src_pin = 1 it is set by cap_evt[0] and lsclk_evt is ignored.
- R11: A read or a write with sel = 0 neither arms, clears nor disarms any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| rd_en | input | 1 | Read strobe (arms the bits) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current register value |
| cap_evt | input | 4 | Capture edge pulses for inputs A to D |
| lsclk_evt | input | 1 | Slow divided clock edge pulse (flag A source, channel 0) |
| a_src_pin | input | 1 | Flag A source: 1 = capture pin A, 0 = slow clock |
| ovf_evt | input | 1 | Counter overflow pulse |

## Verification
The hardest situation to reach is a flag that sets in the window between a read that returned 0 and the write that follows. Cases that are just as hard are a set and a clear that fall in one cycle, and a stale arm left behind by an earlier write of 1. The bench reaches them by placing event pulses and bus strobes on chosen cycles. It puts one read, then a single event pulse, then a write of 0, each on its own cycle, and it also drives an event pulse in the same cycle as a clearing write. It then checks the read data in the cycle after each step.

// File: rtl/cap_status_pkg.sv
package cap_status_pkg;
  localparam int REG_W   = 8;
  localparam int N_CAP   = 4;
  localparam int N_FLAG  = N_CAP + 1;
  localparam int IDX_A   = 0;
  localparam int IDX_OVF = N_CAP;
  localparam int IDX_UDF = N_CAP + 1;

  // next flag value: a set event outranks a clear
  function automatic logic flag_next(logic cur, logic set_i, logic clr_i);
    return set_i | (cur & ~clr_i);
  endfunction

  // a bit clears when it is armed and written with 0
  function automatic logic clear_hit(logic wr_i, logic armed_i, logic wbit_i);
    return wr_i & armed_i & ~wbit_i;
  endfunction

  // value of the bits above the live flags
  function automatic logic [REG_W-N_FLAG-1:0] upper_bits(bit chan0);
    logic [REG_W-N_FLAG-1:0] v;
    v = '1;
    if (!chan0) v[0] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/cap_flag_cell.sv
module cap_flag_cell
  import cap_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wbit,
  output logic flag_o,
  output logic armed_o,
  output logic clr_hit_o
);
  logic flag_q;
  logic armed_q;

  assign clr_hit_o = clear_hit(wr_hit, armed_q, wbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, set_evt, clr_hit_o);
      if (wr_hit)      armed_q <= 1'b0;
      else if (rd_hit) armed_q <= flag_q;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  // R7: a set event always leaves the flag at 1
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R4: a flag only falls after an armed clearing write
  p_fall_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_hit_o) |=> flag_q);

  // R6: writing 1 never clears
  p_write_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_hit && wbit) |=> flag_q);
endmodule

// File: rtl/cap_flag_a_src.sv
module cap_flag_a_src #(
  parameter bit CHAN0 = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_evt,
  input  logic lsclk_evt,
  input  logic a_src_pin,
  output logic set_a
);
  generate
    if (CHAN0) begin : g_sel
      assign set_a = a_src_pin ? pin_evt : lsclk_evt;
    end else begin : g_pin
      assign set_a = pin_evt;
    end
  endgenerate

  // R10: the unselected source never sets flag A
  if (CHAN0) begin : g_chk
    p_src_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_src_pin && !pin_evt) || (!a_src_pin && !lsclk_evt) |-> !set_a);
  end
endmodule

// File: rtl/cap_status_readback.sv
module cap_status_readback
  import cap_status_pkg::*;
#(
  parameter bit CHAN0 = 1'b1
) (
  input  logic [N_FLAG-1:0] flags,
  output logic [REG_W-1:0]  rdata
);
  assign rdata = {upper_bits(CHAN0), flags};
endmodule

// File: rtl/cap_status_reg.sv
module cap_status_reg
  import cap_status_pkg::*;
#(
  parameter bit CHAN0 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [N_CAP-1:0] cap_evt,
  input  logic             lsclk_evt,
  input  logic             a_src_pin,
  input  logic             ovf_evt
);
  logic              rd_hit;
  logic              wr_hit;
  logic              set_a;
  logic [N_FLAG-1:0] set_vec;
  logic [N_FLAG-1:0] flag_vec;
  logic [N_FLAG-1:0] armed_vec;
  logic [N_FLAG-1:0] clr_vec;

  assign rd_hit = sel & rd_en;
  assign wr_hit = sel & wr_en;

  cap_flag_a_src #(.CHAN0(CHAN0)) u_asrc (
    .clk(clk), .rst_n(rst_n), .pin_evt(cap_evt[IDX_A]),
    .lsclk_evt(lsclk_evt), .a_src_pin(a_src_pin), .set_a(set_a)
  );

  assign set_vec = {ovf_evt, cap_evt[N_CAP-1:1], set_a};

  for (genvar i = 0; i < N_FLAG; i++) begin : g_bit
    cap_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_evt(set_vec[i]),
      .rd_hit(rd_hit), .wr_hit(wr_hit), .wbit(wdata[i]),
      .flag_o(flag_vec[i]), .armed_o(armed_vec[i]), .clr_hit_o(clr_vec[i])
    );
  end

  cap_status_readback #(.CHAN0(CHAN0)) u_rb (
    .flags(flag_vec), .rdata(rdata)
  );

  // R8: any selected write leaves no bit armed
  p_write_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (armed_vec == '0));

  // R11: unselected strobes change neither arms nor clears
  p_unselected_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(armed_vec));

  // R5: an unarmed bit is never cleared
  p_unarmed_no_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~armed_vec) == '0);
endmodule

// File: tb/cap_status_reg_tb.sv
module cap_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 0, rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [3:0] cap_evt = 0;
  logic       lsclk_evt = 0, a_src_pin = 1, ovf_evt = 0;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cap_status_reg #(.CHAN0(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cap_evt(cap_evt), .lsclk_evt(lsclk_evt),
    .a_src_pin(a_src_pin), .ovf_evt(ovf_evt)
  );

  task automatic check(string req, logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic rd(logic s = 1);
    sel = s; rd_en = 1;
    @(posedge clk); @(negedge clk);
    sel = 0; rd_en = 0;
  endtask

  task automatic wr(logic [7:0] d, logic s = 1);
    sel = s; wr_en = 1; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 0; wr_en = 0; wdata = 0;
  endtask

  task automatic pulse(logic [3:0] c, logic l = 0, logic o = 0);
    cap_evt = c; lsclk_evt = l; ovf_evt = o;
    @(posedge clk); @(negedge clk);
    cap_evt = 0; lsclk_evt = 0; ovf_evt = 0;
  endtask

  task automatic clear_all();
    rd(); wr(8'h00);
  endtask

  task automatic t_reset();
    check("R1", 8'hE0);
    wr(8'h00);
    check("R9", 8'hE0);
  endtask

  task automatic t_capture();
    pulse(4'b1110);
    check("R2", 8'hEE);
    clear_all();
    check("R4", 8'hE0);
    pulse(0, 0, 1);
    check("R3", 8'hF0);
    clear_all();
    check("R4", 8'hE0);
  endtask

  task automatic t_late_set();
    rd();
    pulse(4'b0010);
    wr(8'h00);
    check("R5", 8'hE2);
    clear_all();
    check("R5", 8'hE0);
  endtask

  task automatic t_write_one();
    pulse(4'b0100);
    rd();
    wr(8'hFF);
    check("R6", 8'hE4);
    wr(8'h00);
    check("R8", 8'hE4);
    clear_all();
    check("R8", 8'hE0);
  endtask

  task automatic t_set_wins();
    pulse(4'b1000);
    rd();
    sel = 1; wr_en = 1; wdata = 8'h00; cap_evt = 4'b1000;
    @(posedge clk); @(negedge clk);
    sel = 0; wr_en = 0; cap_evt = 0;
    check("R7", 8'hE8);
    clear_all();
    check("R7", 8'hE0);
  endtask

  task automatic t_src();
    a_src_pin = 0;
    pulse(4'b0001);
    check("R10", 8'hE0);
    pulse(0, 1);
    check("R10", 8'hE1);
    clear_all();
    a_src_pin = 1;
    pulse(0, 1);
    check("R10", 8'hE0);
    pulse(4'b0001);
    check("R10", 8'hE1);
    clear_all();
    check("R10", 8'hE0);
  endtask

  task automatic t_unselected();
    pulse(4'b0010);
    rd(0);
    wr(8'h00);
    check("R11", 8'hE2);
    rd();
    wr(8'h00, 0);
    check("R11", 8'hE2);
    wr(8'h00);
    check("R11", 8'hE0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_late_set();
    t_write_one();
    t_set_wins();
    t_src();
    t_unselected();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule